// File: doc/BRIEF.md
# Channel Event Interrupt Aggregator

This block gathers the one-cycle event strobes from four transmit and four receive pulse channels into one sticky interrupt register set, and drives a single combined interrupt line. Each channel owns a group of three adjacent bits: transmit completion, receive completion and an error bit that both directions of that channel share. Two further banks in the upper part of the used range carry the transmit threshold and transmit loop-end events, one bit per channel. Receive has no threshold event, so no bit is reserved for it.

Software reaches the block through a generic register port with a write strobe, a 3-bit address and a 32-bit data word. It reads the latched raw events, the enable mask and the masked view. It clears events by writing a mask. It edits the enable mask either as a whole or by setting or clearing selected bits. The combined interrupt is a registered OR of the masked bits.

Top module: `evt_irq_agg`

## Requirements
- R1: A transmit-done strobe on channel n sets raw bit 3n, and a receive-done strobe on channel n sets raw bit 3n+1.
- R2: A transmit-error or receive-error strobe on channel n sets raw bit 3n+2. Both sides share that one bit.
- R3: A transmit-threshold strobe on channel n sets raw bit 12+n, and a transmit loop-end strobe on channel n sets raw bit 16+n.
- R4: Raw bits are sticky. A bit holds once set until it is cleared, and no raw bit rises without its strobe.
- R5: A write to address 3 clears exactly the raw bits that are set in the written data. All other raw bits keep their value.
- R6: When a strobe and a clear reach the same raw bit in the same cycle, the bit ends set.
- R7: A read of address 2 returns the raw bits ANDed with the enable mask. A read of address 0 returns the raw bits. A read of address 1 returns the enable mask.
- R8: A write to address 1 replaces the enable mask. A write to address 4 sets the enable bits that are 1 in the data. A write to address 5 clears the enable bits that are 1 in the data. In both of the last two cases, the other enable bits keep their value.
- R9: irq_o is high in the cycle after the one in which any masked bit is set, and low in the cycle after the one in which none is.
- R10: Bits 31 down to 20 of every register read as zero, and writes to them have no effect. A write to the raw address 0 or the masked address 2 changes nothing.
- R11: After reset, the raw bits and enable bits are all zero and irq_o is low.
- R12: Reads of address 3 and of addresses 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_done_i | input | 4 | Transmit completion strobes, one per channel |
| rx_done_i | input | 4 | Receive completion strobes, one per channel |
| tx_err_i | input | 4 | Transmit error strobes, one per channel |
| rx_err_i | input | 4 | Receive error strobes, one per channel |
| tx_thr_i | input | 4 | Transmit threshold strobes, one per channel |
| tx_loop_i | input | 4 | Transmit loop-end strobes, one per channel |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
If a strobe lands on the wrong bit position, this shows in the raw read at the very next clock. If the sticky or clear logic is wrong, the raw read shows either a lost bit or a bit that stays set, one edge after the write. If the enable mask has a bad bit, it shows in the masked read in the same cycle. It also shows on irq_o one edge later, because the line follows the masked OR with a single register stage.

// File: rtl/evt_irq_agg_pkg.sv
package evt_irq_agg_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_RAW  = 3'd0,
    SEL_ENA  = 3'd1,
    SEL_STAT = 3'd2,
    SEL_CLR  = 3'd3,
    SEL_ESET = 3'd4,
    SEL_ECLR = 3'd5
  } reg_sel_e;

  // Per-channel group of three: done-tx, done-rx, shared error
  function automatic int pos_tx_done(input int n);
    return 3 * n;
  endfunction

  function automatic int pos_rx_done(input int n);
    return 3 * n + 1;
  endfunction

  function automatic int pos_err(input int n);
    return 3 * n + 2;
  endfunction

  // Banks above the per-channel groups
  function automatic int pos_thr(input int nch, input int n);
    return 3 * nch + n;
  endfunction

  function automatic int pos_loop(input int nch, input int n);
    return 4 * nch + n;
  endfunction

  function automatic int used_bits(input int nch);
    return 5 * nch;
  endfunction

endpackage

// File: rtl/evt_irq_map.sv
module evt_irq_map
  import evt_irq_agg_pkg::*;
#(
  parameter int NCH = 4,
  parameter int EW  = used_bits(NCH)
) (
  input  logic [NCH-1:0] tx_done,
  input  logic [NCH-1:0] rx_done,
  input  logic [NCH-1:0] tx_err,
  input  logic [NCH-1:0] rx_err,
  input  logic [NCH-1:0] tx_thr,
  input  logic [NCH-1:0] tx_loop,
  output logic [EW-1:0]  set_vec
);

  always_comb begin
    set_vec = '0;
    for (int n = 0; n < NCH; n++) begin
      set_vec[pos_tx_done(n)]   = tx_done[n];
      set_vec[pos_rx_done(n)]   = rx_done[n];
      set_vec[pos_err(n)]       = tx_err[n] | rx_err[n];
      set_vec[pos_thr(NCH, n)]  = tx_thr[n];
      set_vec[pos_loop(NCH, n)] = tx_loop[n];
    end
  end

endmodule

// File: rtl/evt_irq_sticky.sv
module evt_irq_sticky #(
  parameter int EW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] set_vec,
  input  logic [EW-1:0] clr_vec,
  output logic [EW-1:0] raw_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~clr_vec) | set_vec;
  end

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q & ~clr_vec) != '0 |=>
      (raw_q & $past(raw_q & ~clr_vec)) == $past(raw_q & ~clr_vec));

  // R4
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (raw_q & ~$past(raw_q | set_vec)) == '0);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec != '0 |=> (raw_q & $past(set_vec)) == $past(set_vec));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec & ~set_vec) != '0 |=> (raw_q & $past(clr_vec & ~set_vec)) == '0);

endmodule

// File: rtl/evt_irq_enable.sv
module evt_irq_enable #(
  parameter int EW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_all,
  input  logic          wr_set,
  input  logic          wr_clr,
  input  logic [EW-1:0] wdata,
  output logic [EW-1:0] ena_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ena_q <= '0;
    else if (wr_all) ena_q <= wdata;
    else if (wr_set) ena_q <= ena_q | wdata;
    else if (wr_clr) ena_q <= ena_q & ~wdata;
  end

  // R8
  ena_set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set && !wr_all |=>
      ((ena_q & ~$past(wdata)) == ($past(ena_q) & ~$past(wdata))) &&
      ((ena_q & $past(wdata)) == $past(wdata)));

  // R8
  ena_clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr && !wr_all && !wr_set |=>
      ((ena_q & ~$past(wdata)) == ($past(ena_q) & ~$past(wdata))) &&
      ((ena_q & $past(wdata)) == '0));

endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
  import evt_irq_agg_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    tx_done_i,
  input  logic [NCH-1:0]    rx_done_i,
  input  logic [NCH-1:0]    tx_err_i,
  input  logic [NCH-1:0]    rx_err_i,
  input  logic [NCH-1:0]    tx_thr_i,
  input  logic [NCH-1:0]    tx_loop_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_o
);

  localparam int EW = used_bits(NCH);

  logic [EW-1:0] set_vec;
  logic [EW-1:0] clr_vec;
  logic [EW-1:0] raw_q;
  logic [EW-1:0] ena_q;
  logic [EW-1:0] status_w;
  logic [EW-1:0] wdata_used;
  logic          wr_all, wr_set, wr_clr;

  assign wdata_used = reg_wdata_i[EW-1:0];

  generate
    if (DW > EW) begin : g_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^reg_wdata_i[DW-1:EW];
    end
  endgenerate

  // Write decode
  assign wr_all  = reg_we_i && (reg_addr_i == SEL_ENA);
  assign wr_set  = reg_we_i && (reg_addr_i == SEL_ESET);
  assign wr_clr  = reg_we_i && (reg_addr_i == SEL_ECLR);
  assign clr_vec = (reg_we_i && (reg_addr_i == SEL_CLR)) ? wdata_used : '0;

  evt_irq_map #(.NCH(NCH), .EW(EW)) u_map (
    .tx_done (tx_done_i),
    .rx_done (rx_done_i),
    .tx_err  (tx_err_i),
    .rx_err  (rx_err_i),
    .tx_thr  (tx_thr_i),
    .tx_loop (tx_loop_i),
    .set_vec (set_vec)
  );

  evt_irq_sticky #(.EW(EW)) u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .raw_q   (raw_q)
  );

  evt_irq_enable #(.EW(EW)) u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_all (wr_all),
    .wr_set (wr_set),
    .wr_clr (wr_clr),
    .wdata  (wdata_used),
    .ena_q  (ena_q)
  );

  assign status_w = raw_q & ena_q;

  // Read mux, zero-extended to the port width
  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      SEL_RAW:  reg_rdata_o[EW-1:0] = raw_q;
      SEL_ENA:  reg_rdata_o[EW-1:0] = ena_q;
      SEL_STAT: reg_rdata_o[EW-1:0] = status_w;
      default:  reg_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |status_w;
  end

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> irq_o == $past(|(raw_q & ena_q)));

  // R10
  generate
    if (DW > EW) begin : g_hi_chk
      always_comb begin
        if (rst_n) begin
          upper_zero_chk: assert (reg_rdata_o[DW-1:EW] == '0);
        end
      end
    end
  endgenerate

  // R12
  always_comb begin
    if (rst_n && (reg_addr_i == SEL_CLR || reg_addr_i > SEL_ECLR)) begin
      empty_read_chk: assert (reg_rdata_o == '0);
    end
  end

endmodule

// File: tb/evt_irq_agg_bench.sv
module evt_irq_agg_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tx_done = '0, rx_done = '0, tx_err = '0, rx_err = '0;
  logic [3:0]  tx_thr = '0, tx_loop = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  evt_irq_agg u_evt_irq_agg (
    .clk (clk), .rst_n (rst_n),
    .tx_done_i (tx_done), .rx_done_i (rx_done),
    .tx_err_i (tx_err), .rx_err_i (rx_err),
    .tx_thr_i (tx_thr), .tx_loop_i (tx_loop),
    .reg_we_i (we), .reg_addr_i (addr), .reg_wdata_i (wdata),
    .reg_rdata_o (rdata), .irq_o (irq)
  );

  typedef struct packed {
    logic [3:0]  tx, rx, te, re, th, lp;
    logic        w;
    logic [2:0]  a;
    logic [31:0] d;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,3'd1,32'hFFFF_FFFF},
    '{4'h1,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,3'd0,32'h0},
    '{4'h0,4'h2,4'h0,4'h0,4'h0,4'h0,1'b0,3'd0,32'h0},
    '{4'h0,4'h0,4'h4,4'h8,4'h0,4'h0,1'b0,3'd0,32'h0},
    '{4'h0,4'h0,4'h0,4'h0,4'h5,4'h0,1'b0,3'd0,32'h0},
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'hA,1'b0,3'd0,32'h0},
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,3'd3,32'h0000_0011},
    '{4'h2,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,3'd3,32'h0000_1008},
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,3'd5,32'h000F_FFF0},
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,3'd4,32'h0000_0100},
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,3'd1,32'h0000_0000},
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,3'd3,32'hFFFF_FFFF},
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,3'd1,32'hFFF0_0800},
    '{4'h0,4'h0,4'h0,4'h8,4'h0,4'h0,1'b0,3'd0,32'h0},
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,3'd0,32'hFFFF_FFFF},
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,3'd2,32'hFFFF_FFFF}
  };

  logic [31:0] m_raw = '0, m_ena = '0;
  localparam logic [31:0] USED = 32'h000F_FFFF;

  // Bench restatement of bit placement: channel groups of 3, then two banks of 4
  function automatic logic [31:0] place(input vec_t v);
    logic [31:0] r = '0;
    for (int c = 0; c < 4; c++) begin
      r |= 32'(v.tx[c]) << (c * 3);
      r |= 32'(v.rx[c]) << (c * 3 + 1);
      r |= 32'(v.te[c] | v.re[c]) << (c * 3 + 2);
    end
    r |= 32'(v.th) << 12;
    r |= 32'(v.lp) << 16;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    tx_done = v.tx; rx_done = v.rx; tx_err = v.te; rx_err = v.re;
    tx_thr = v.th; tx_loop = v.lp; we = v.w; addr = v.a; wdata = v.d;
    @(negedge clk);
    tx_done = '0; rx_done = '0; tx_err = '0; rx_err = '0;
    tx_thr = '0; tx_loop = '0; we = 1'b0; wdata = '0;
    if (v.w && v.a == 3'd3) m_raw = m_raw & ~(v.d & USED);
    if (v.w && v.a == 3'd1) m_ena = v.d & USED;
    if (v.w && v.a == 3'd4) m_ena = m_ena | (v.d & USED);
    if (v.w && v.a == 3'd5) m_ena = m_ena & ~(v.d & USED);
    m_raw = m_raw | place(v);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    rd(3'd0, d); chk({tag, " R1 R2 R3 R4 R5 R6 raw"}, d, m_raw);
    rd(3'd1, d); chk({tag, " R8 enable"}, d, m_ena);
    rd(3'd2, d); chk({tag, " R7 masked"}, d, m_raw & m_ena);
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] d;
    // R11 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, d); chk("R11 raw", d, 32'h0);
    rd(3'd1, d); chk("R11 enable", d, 32'h0);
    chk("R11 irq", 32'(irq), 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      check_all($sformatf("vec%0d", i));
      @(negedge clk);
      chk($sformatf("vec%0d R9 irq", i), 32'(irq), 32'(|(m_raw & m_ena)));
    end

    // R1 literal: transmit done on channel 3 lands on bit 9
    apply('{4'h8,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,3'd3,32'hFFFF_FFFF});
    rd(3'd0, d); chk("R1 ch3 tx done", d, 32'h0000_0200);
    // R3 literal: loop end ch0 -> bit 16; threshold ch3 -> bit 15
    apply('{4'h0,4'h0,4'h0,4'h0,4'h8,4'h1,1'b1,3'd3,32'h0000_0200});
    rd(3'd0, d); chk("R3 banks", d, 32'h0001_8000);
    // R2 literal: receive error ch1 -> bit 5
    apply('{4'h0,4'h0,4'h0,4'h2,4'h0,4'h0,1'b0,3'd0,32'h0});
    rd(3'd0, d); chk("R2 shared err", d, 32'h0001_8020);
    m_raw = 32'h0001_8020;

    // R12 empty addresses
    rd(3'd3, d); chk("R12 addr3", d, 32'h0);
    rd(3'd6, d); chk("R12 addr6", d, 32'h0);
    rd(3'd7, d); chk("R12 addr7", d, 32'h0);

    // R10: upper enable bits ignored
    apply('{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,3'd1,32'hFFFF_FFFF});
    rd(3'd1, d); chk("R10 enable upper", d, 32'h000F_FFFF);
    m_ena = 32'h000F_FFFF;

    // R9 timing: after a clear-all, irq drops one edge later
    @(negedge clk);
    chk("R9 irq before clear", 32'(irq), 32'h1);
    we = 1'b1; addr = 3'd3; wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    we = 1'b0; wdata = '0;
    chk("R9 irq one edge after clear", 32'(irq), 32'h1);
    @(negedge clk);
    chk("R9 irq two edges after clear", 32'(irq), 32'h0);
    rd(3'd0, d); chk("R5 clear all", d, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule